// File: doc/BRIEF.md
# Device Discovery Register Controller

This block is a memory-mapped peripheral that lets software find a fixed set of attached devices one at a time. It holds a small table of device descriptors. Each descriptor carries an identifier, an I/O window base and size, a first interrupt line, an interrupt count and a name length. Each entry also has a flag that records whether software has already been told about it. The controller always occupies entry 0 of its own table. The other entries come from parameters and are fixed at reset.

Software starts a discovery pass by writing the start command. The controller then raises its interrupt. Each read of the status register marks the entry under the cursor as reported and moves the cursor to the next unreported entry. The read returns a "device present" code while an entry remains, and a "finished" code once none is left. The finished result also drops the interrupt. While the cursor points at an entry, the descriptor registers show that entry. A name-copy command sends the entry's name length and a 64-bit destination address to a copy engine over a valid/ready handshake. The upper half of that address comes from an earlier write, which also sets a sticky wide-address flag. An access that the controller does not define is answered with an error response and sets a sticky error flag.

Top module: `devdisc_ctrl`

## Requirements
- R1: After reset, the interrupt, the error flag, the wide-address flag, the copy request and the response valid are all 0, and the cursor points at no entry.
- R2: Writing 0 to the status register (offset 0x00) clears every reported flag and leaves the cursor pointing at no entry. In the cycle after the access, the interrupt is 1.
- R3: On a status read, the entry under the cursor (if any) is first marked reported. The search then starts from the next index, or from index 0 when the cursor points at no entry, and the cursor moves to the lowest unreported entry at or after that index. The read returns 0x08 when such an entry exists.
- R4: When the search finds no unreported entry, the status read returns 0x00, the cursor points at no entry, and the interrupt is 0 from the cycle the response appears.
- R5: Entries already marked reported are skipped. After a pass has finished, further status reads return 0x00 until the next start command.
- R6: Reads of name length (0x08), id (0x0C), base (0x10), size (0x14), first interrupt (0x18) and interrupt count (0x1C) return the field of the entry under the cursor, or 0 when the cursor points at no entry.
- R7: Entry 0 reads as id 0xFFFFFFFF, base 0x10001000, size 0x1000, first interrupt 1 and interrupt count 1.
- R8: A write to 0x20 stores the upper 32 bits of the name address and sets a sticky wide-address flag.
- R9: A write to 0x04 while the cursor points at an entry raises a copy request. The request carries the stored upper word joined with the written lower word as its address, and the entry's name length as its count. With no entry under the cursor, the write does nothing.
- R10: The request stays raised, with a stable address and count, until the copy engine is ready. A 0x04 write that arrives while a request is pending and not being accepted is held off, with bus ready at 0.
- R11: The following accesses get an error response: a read of 0x04 or 0x20, a write to any offset other than 0x00, 0x04 or 0x20, any access to an undefined offset, and a write to 0x00 with a nonzero value. Such an access sets the sticky error flag and changes nothing else.
- R12: Every accepted access gets exactly one response, one cycle later. A write response carries read data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access accepted when high with bus_valid |
| rsp_valid | output | 1 | Response strobe, one cycle after accept |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Error response |
| irq_o | output | 1 | Discovery interrupt |
| err_flag_o | output | 1 | Sticky error flag |
| host64_o | output | 1 | Sticky wide-address flag |
| cpy_valid | output | 1 | Name-copy request valid |
| cpy_ready | input | 1 | Copy engine ready |
| cpy_addr | output | 64 | Name destination address |
| cpy_len | output | 32 | Byte count to copy |

## Verification
A wrong reported flag or a wrong cursor index shows up on the next status or descriptor read. Depending on the fault, the read repeats an entry, skips an entry, or returns the finished code too early, and the interrupt drops too early or too late in that same response cycle. The bench therefore walks complete passes and checks every response against an expected list of entries. It restarts one pass part-way through and reads again after a pass has finished. Faults in error handling or in the copy handshake appear within one or two cycles, as a cursor that moved after an error, a changed request address, or bus ready that stays high during back-pressure.

// File: rtl/devdisc_pkg.sv
package devdisc_pkg;
  localparam int DW      = 32;
  localparam int MAX_ENT = 8;
  localparam int IDX_W   = $clog2(MAX_ENT);

  localparam logic [31:0] OFS_STAT   = 32'h00;
  localparam logic [31:0] OFS_NAMECP = 32'h04;
  localparam logic [31:0] OFS_NLEN   = 32'h08;
  localparam logic [31:0] OFS_ID     = 32'h0C;
  localparam logic [31:0] OFS_BASE   = 32'h10;
  localparam logic [31:0] OFS_SIZE   = 32'h14;
  localparam logic [31:0] OFS_IRQ    = 32'h18;
  localparam logic [31:0] OFS_IRQCNT = 32'h1C;
  localparam logic [31:0] OFS_ADRHI  = 32'h20;

  localparam logic [DW-1:0] ST_FINISHED = 32'h0;
  localparam logic [DW-1:0] ST_PRESENT  = 32'h8;

  typedef struct packed {
    logic [DW-1:0] id;
    logic [DW-1:0] base;
    logic [DW-1:0] size;
    logic [DW-1:0] irq;
    logic [DW-1:0] irqcnt;
    logic [DW-1:0] nlen;
  } desc_t;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
  } seek_t;

  typedef enum logic [2:0] {
    K_STAT_RD, K_START, K_NAMECP, K_ADRHI, K_FIELD_RD, K_BAD
  } acc_kind_e;

  // lowest index >= start and < n whose reported bit is clear
  function automatic seek_t seek_unreported(logic [MAX_ENT-1:0] seen, int start, int n);
    seek_t r;
    r = '0;
    for (int i = 0; i < MAX_ENT; i++) begin
      if (!r.hit && i >= start && i < n && !seen[i]) begin
        r.hit = 1'b1;
        r.idx = IDX_W'(i);
      end
    end
    return r;
  endfunction

  function automatic acc_kind_e classify(logic wr, logic [31:0] ofs, logic zero_val);
    if (wr) begin
      if (ofs == OFS_STAT)   return zero_val ? K_START : K_BAD;
      if (ofs == OFS_NAMECP) return K_NAMECP;
      if (ofs == OFS_ADRHI)  return K_ADRHI;
      return K_BAD;
    end
    if (ofs == OFS_STAT) return K_STAT_RD;
    if (ofs == OFS_NLEN || ofs == OFS_ID || ofs == OFS_BASE ||
        ofs == OFS_SIZE || ofs == OFS_IRQ || ofs == OFS_IRQCNT) return K_FIELD_RD;
    return K_BAD;
  endfunction

  function automatic logic [DW-1:0] pick_field(desc_t d, logic [31:0] ofs);
    case (ofs)
      OFS_NLEN:   return d.nlen;
      OFS_ID:     return d.id;
      OFS_BASE:   return d.base;
      OFS_SIZE:   return d.size;
      OFS_IRQ:    return d.irq;
      OFS_IRQCNT: return d.irqcnt;
      default:    return '0;
    endcase
  endfunction
endpackage

// File: rtl/devdisc_table.sv
module devdisc_table
  import devdisc_pkg::*;
#(
  parameter int NUM_ENT = 4,
  parameter logic [DW-1:0] SELF_BASE = 32'h1000_1000,
  parameter logic [DW-1:0] SELF_SIZE = 32'h0000_1000,
  parameter logic [DW-1:0] SELF_IRQ  = 32'd1,
  parameter logic [DW-1:0] SELF_NLEN = 32'd19,
  parameter logic [MAX_ENT-1:0][DW-1:0] ENT_ID   = '0,
  parameter logic [MAX_ENT-1:0][DW-1:0] ENT_BASE = '0,
  parameter logic [MAX_ENT-1:0][DW-1:0] ENT_SIZE = '0,
  parameter logic [MAX_ENT-1:0][DW-1:0] ENT_IRQ  = '0,
  parameter logic [MAX_ENT-1:0][DW-1:0] ENT_CNT  = '0,
  parameter logic [MAX_ENT-1:0][DW-1:0] ENT_NLEN = '0
) (
  input  logic             vld_i,
  input  logic [IDX_W-1:0] idx_i,
  output desc_t            sel_o
);
  desc_t rows [MAX_ENT];

  for (genvar g = 0; g < MAX_ENT; g++) begin : g_row
    if (g == 0) begin : g_self
      assign rows[g] = '{id: '1, base: SELF_BASE, size: SELF_SIZE,
                         irq: SELF_IRQ, irqcnt: 32'd1, nlen: SELF_NLEN};
    end else if (g < NUM_ENT) begin : g_dev
      assign rows[g] = '{id: ENT_ID[g], base: ENT_BASE[g], size: ENT_SIZE[g],
                         irq: ENT_IRQ[g], irqcnt: ENT_CNT[g], nlen: ENT_NLEN[g]};
    end else begin : g_empty
      assign rows[g] = '0;
    end
  end

  assign sel_o = vld_i ? rows[idx_i] : '0;
endmodule

// File: rtl/devdisc_walk.sv
module devdisc_walk
  import devdisc_pkg::*;
#(
  parameter int NUM_ENT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             step_i,
  output logic             cur_vld_o,
  output logic [IDX_W-1:0] cur_idx_o,
  output logic             found_o
);
  logic [MAX_ENT-1:0] seen_q, seen_mark;
  int                 from;
  seek_t              sk;

  always_comb begin
    seen_mark = seen_q;
    if (cur_vld_o) seen_mark[cur_idx_o] = 1'b1;
    from = cur_vld_o ? int'(cur_idx_o) + 1 : 0;
    sk   = seek_unreported(seen_mark, from, NUM_ENT);
  end

  assign found_o = sk.hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q    <= '0;
      cur_vld_o <= 1'b0;
      cur_idx_o <= '0;
    end else if (start_i) begin
      seen_q    <= '0;
      cur_vld_o <= 1'b0;
    end else if (step_i) begin
      seen_q    <= seen_mark;
      cur_vld_o <= sk.hit;
      if (sk.hit) cur_idx_o <= sk.idx;
    end
  end
endmodule

// File: rtl/devdisc_namereq.sv
module devdisc_namereq
  import devdisc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [2*DW-1:0] addr_i,
  input  logic [DW-1:0]   len_i,
  input  logic            cpy_ready,
  output logic            cpy_valid,
  output logic [2*DW-1:0] cpy_addr,
  output logic [DW-1:0]   cpy_len
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpy_valid <= 1'b0;
      cpy_addr  <= '0;
      cpy_len   <= '0;
    end else if (load_i) begin
      cpy_valid <= 1'b1;
      cpy_addr  <= addr_i;
      cpy_len   <= len_i;
    end else if (cpy_valid && cpy_ready) begin
      cpy_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/devdisc_ctrl.sv
module devdisc_ctrl
  import devdisc_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NUM_ENT = 4,
  parameter logic [DW-1:0] SELF_BASE = 32'h1000_1000,
  parameter logic [DW-1:0] SELF_SIZE = 32'h0000_1000,
  parameter logic [DW-1:0] SELF_IRQ  = 32'd1,
  parameter logic [DW-1:0] SELF_NLEN = 32'd19,
  parameter logic [MAX_ENT-1:0][DW-1:0] ENT_ID =
    {32'h77, 32'h66, 32'h55, 32'h44, 32'h33, 32'h22, 32'h11, 32'h0},
  parameter logic [MAX_ENT-1:0][DW-1:0] ENT_BASE =
    {32'h1000_8000, 32'h1000_7000, 32'h1000_6000, 32'h1000_5100,
     32'h1000_5000, 32'h1000_3000, 32'h1000_2000, 32'h0},
  parameter logic [MAX_ENT-1:0][DW-1:0] ENT_SIZE =
    {32'h1000, 32'h1000, 32'h1000, 32'h0F00, 32'h0100, 32'h2000, 32'h1000, 32'h0},
  parameter logic [MAX_ENT-1:0][DW-1:0] ENT_IRQ =
    {32'd9, 32'd8, 32'd7, 32'd6, 32'd5, 32'd3, 32'd2, 32'd0},
  parameter logic [MAX_ENT-1:0][DW-1:0] ENT_CNT =
    {32'd1, 32'd1, 32'd1, 32'd1, 32'd0, 32'd2, 32'd1, 32'd0},
  parameter logic [MAX_ENT-1:0][DW-1:0] ENT_NLEN =
    {32'd4, 32'd4, 32'd4, 32'd4, 32'd3, 32'd7, 32'd5, 32'd0}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic              bus_ready,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic              rsp_err,
  output logic              irq_o,
  output logic              err_flag_o,
  output logic              host64_o,
  output logic              cpy_valid,
  input  logic              cpy_ready,
  output logic [2*DW-1:0]   cpy_addr,
  output logic [DW-1:0]     cpy_len
);
  localparam int OFS_PAD = 32 - ADDR_W;

  // named internal events
  logic [31:0]      ofs;
  acc_kind_e        kind;
  logic             acc_fire, stat_rd, start_cmd, namecp_wr, adrhi_wr, acc_err;
  logic             cur_vld, found;
  logic [IDX_W-1:0] cur_idx;
  desc_t            cur;
  logic [DW-1:0]    adr_hi_q, rd_val;

  assign ofs  = {{OFS_PAD{1'b0}}, bus_addr};
  assign kind = classify(bus_write, ofs, bus_wdata == '0);

  assign bus_ready = !(kind == K_NAMECP && cpy_valid && !cpy_ready);
  assign acc_fire  = bus_valid && bus_ready;
  assign stat_rd   = acc_fire && kind == K_STAT_RD;
  assign start_cmd = acc_fire && kind == K_START;
  assign namecp_wr = acc_fire && kind == K_NAMECP && cur_vld;
  assign adrhi_wr  = acc_fire && kind == K_ADRHI;
  assign acc_err   = acc_fire && kind == K_BAD;

  devdisc_walk #(.NUM_ENT(NUM_ENT)) walk_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_cmd), .step_i(stat_rd),
    .cur_vld_o(cur_vld), .cur_idx_o(cur_idx), .found_o(found)
  );

  devdisc_table #(
    .NUM_ENT(NUM_ENT), .SELF_BASE(SELF_BASE), .SELF_SIZE(SELF_SIZE),
    .SELF_IRQ(SELF_IRQ), .SELF_NLEN(SELF_NLEN), .ENT_ID(ENT_ID),
    .ENT_BASE(ENT_BASE), .ENT_SIZE(ENT_SIZE), .ENT_IRQ(ENT_IRQ),
    .ENT_CNT(ENT_CNT), .ENT_NLEN(ENT_NLEN)
  ) table_i (
    .vld_i(cur_vld), .idx_i(cur_idx), .sel_o(cur)
  );

  devdisc_namereq namereq_i (
    .clk(clk), .rst_n(rst_n), .load_i(namecp_wr),
    .addr_i({adr_hi_q, bus_wdata}), .len_i(cur.nlen),
    .cpy_ready(cpy_ready), .cpy_valid(cpy_valid),
    .cpy_addr(cpy_addr), .cpy_len(cpy_len)
  );

  always_comb begin
    case (kind)
      K_STAT_RD:  rd_val = found ? ST_PRESENT : ST_FINISHED;
      K_FIELD_RD: rd_val = pick_field(cur, ofs);
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o      <= 1'b0;
      err_flag_o <= 1'b0;
      host64_o   <= 1'b0;
      adr_hi_q   <= '0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      rsp_err    <= 1'b0;
    end else begin
      rsp_valid <= acc_fire;
      rsp_err   <= acc_err;
      rsp_rdata <= acc_fire ? rd_val : '0;
      if (start_cmd)            irq_o <= (NUM_ENT > 0);
      else if (stat_rd && !found) irq_o <= 1'b0;
      if (acc_err) err_flag_o <= 1'b1;
      if (adrhi_wr) begin
        adr_hi_q <= bus_wdata;
        host64_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/devdisc_ctrl_chk.sv
module devdisc_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_fire,
  input logic        stat_rd,
  input logic        start_cmd,
  input logic        acc_err,
  input logic        found,
  input logic        cur_vld,
  input logic        irq_o,
  input logic        err_flag_o,
  input logic        host64_o,
  input logic        rsp_valid,
  input logic        cpy_valid,
  input logic        cpy_ready,
  input logic [63:0] cpy_addr
);
  AST_START_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    start_cmd |=> irq_o); // R2
  AST_STEP_FOUND_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && found |=> cur_vld); // R3
  AST_FINISH_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !found |=> !irq_o && !cur_vld); // R4
  AST_HOST64_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    host64_o |=> host64_o); // R8
  AST_CPY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cpy_valid && !cpy_ready |=> cpy_valid && $stable(cpy_addr)); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag_o |=> err_flag_o); // R11
  AST_ERR_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |=> $stable(irq_o) && $stable(cur_vld) && err_flag_o); // R11
  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |=> rsp_valid); // R12
  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_fire |=> !rsp_valid); // R12
endmodule

bind devdisc_ctrl devdisc_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .acc_fire(acc_fire), .stat_rd(stat_rd),
  .start_cmd(start_cmd), .acc_err(acc_err), .found(found), .cur_vld(cur_vld),
  .irq_o(irq_o), .err_flag_o(err_flag_o), .host64_o(host64_o),
  .rsp_valid(rsp_valid), .cpy_valid(cpy_valid), .cpy_ready(cpy_ready),
  .cpy_addr(cpy_addr)
);

// File: tb/devdisc_ctrl_tb.sv
`timescale 1ns/1ps
module devdisc_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready, rsp_valid, rsp_err, irq_o, err_flag_o, host64_o;
  logic [31:0] rsp_rdata, cpy_len;
  logic        cpy_valid, cpy_ready = 1'b0;
  logic [63:0] cpy_addr;

  int total = 0, bad = 0;
  logic [31:0] q_data[$];
  bit          q_err[$];
  string       q_tag[$];

  always #2 clk = ~clk;

  devdisc_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .irq_o(irq_o), .err_flag_o(err_flag_o), .host64_o(host64_o),
    .cpy_valid(cpy_valid), .cpy_ready(cpy_ready), .cpy_addr(cpy_addr),
    .cpy_len(cpy_len)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected response per observed response
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q_data.size() == 0) begin
        chk(1'b0, "R12 unexpected response", {32'h0, rsp_rdata}, 64'h0);
      end else begin
        logic [31:0] ed;
        bit          ee;
        string       tg;
        ed = q_data.pop_front();
        ee = q_err.pop_front();
        tg = q_tag.pop_front();
        chk(rsp_rdata == ed && rsp_err == ee, tg, {31'h0, rsp_err, rsp_rdata}, {31'h0, ee, ed});
      end
    end
  end

  // driver: returns at the negedge after acceptance, response already visible
  task automatic acc(input bit wr, input logic [7:0] ofs, input logic [31:0] wd,
                     input logic [31:0] ed, input bit ee, input string tag);
    q_data.push_back(ed);
    q_err.push_back(ee);
    q_tag.push_back(tag);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = ofs; bus_wdata = wd;
    #0.5;
    while (!bus_ready) begin
      @(negedge clk);
      #0.5;
    end
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] ofs, input logic [31:0] ed, input string tag);
    acc(1'b0, ofs, 32'h0, ed, 1'b0, tag);
  endtask

  initial begin
    #(200000 * 4);
    chk(1'b0, "watchdog expired", 64'h0, 64'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(irq_o == 1'b0, "R1 irq", {63'h0, irq_o}, 64'h0);
    chk(err_flag_o == 1'b0 && host64_o == 1'b0, "R1 flags", {62'h0, err_flag_o, host64_o}, 64'h0);
    chk(cpy_valid == 1'b0 && rsp_valid == 1'b0, "R1 strobes", {62'h0, cpy_valid, rsp_valid}, 64'h0);
    rd(8'h0C, 32'h0, "R1 id with no entry");

    // R2 start command
    acc(1'b1, 8'h00, 32'h0, 32'h0, 1'b0, "R12 start write rdata");
    chk(irq_o == 1'b1, "R2 irq raised", {63'h0, irq_o}, 64'h1);

    // R3/R7 entry 0
    rd(8'h00, 32'h8, "R3 first step");
    rd(8'h0C, 32'hFFFF_FFFF, "R7 self id");
    rd(8'h10, 32'h1000_1000, "R7 self base");
    rd(8'h14, 32'h0000_1000, "R7 self size");
    rd(8'h18, 32'd1, "R7 self irq");
    rd(8'h1C, 32'd1, "R7 self irq count");
    rd(8'h08, 32'd19, "R6 self name length");
    rd(8'h00, 32'h8, "R3 second step");
    rd(8'h0C, 32'h11, "R3 entry 1 id");

    // R2 restart mid-pass
    acc(1'b1, 8'h00, 32'h0, 32'h0, 1'b0, "R2 restart");
    rd(8'h00, 32'h8, "R2 step after restart");
    rd(8'h0C, 32'hFFFF_FFFF, "R2 back at entry 0");

    // R8 upper address, R9 copy request
    acc(1'b1, 8'h20, 32'hABCD_0001, 32'h0, 1'b0, "R8 high write");
    chk(host64_o == 1'b1, "R8 wide flag", {63'h0, host64_o}, 64'h1);
    acc(1'b1, 8'h04, 32'h2000_0040, 32'h0, 1'b0, "R9 name write");
    chk(cpy_valid == 1'b1, "R9 request raised", {63'h0, cpy_valid}, 64'h1);
    chk(cpy_addr == 64'hABCD_0001_2000_0040, "R9 address", cpy_addr, 64'hABCD_0001_2000_0040);
    chk(cpy_len == 32'd19, "R9 count", {32'h0, cpy_len}, 64'd19);

    // R10 back-pressure on a second name write
    q_data.push_back(32'h0); q_err.push_back(1'b0); q_tag.push_back("R10 held write rsp");
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h3000_0080;
    #0.5;
    chk(bus_ready == 1'b0, "R10 held off", {63'h0, bus_ready}, 64'h0);
    repeat (2) @(negedge clk);
    #0.5;
    chk(bus_ready == 1'b0 && cpy_addr == 64'hABCD_0001_2000_0040, "R10 still held",
        cpy_addr, 64'hABCD_0001_2000_0040);
    cpy_ready = 1'b1;
    #0.5;
    chk(bus_ready == 1'b1, "R10 released", {63'h0, bus_ready}, 64'h1);
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; cpy_ready = 1'b0;
    chk(cpy_valid == 1'b1 && cpy_addr == 64'hABCD_0001_3000_0080, "R10 new request",
        cpy_addr, 64'hABCD_0001_3000_0080);
    @(negedge clk); cpy_ready = 1'b1;
    @(negedge clk); cpy_ready = 1'b0;
    chk(cpy_valid == 1'b0, "R10 request accepted", {63'h0, cpy_valid}, 64'h0);

    // R11 errors change nothing else
    acc(1'b0, 8'h24, 32'h0, 32'h0, 1'b1, "R11 undefined read");
    chk(err_flag_o == 1'b1, "R11 sticky flag", {63'h0, err_flag_o}, 64'h1);
    acc(1'b1, 8'h00, 32'h5, 32'h0, 1'b1, "R11 nonzero command");
    acc(1'b0, 8'h04, 32'h0, 32'h0, 1'b1, "R11 read of name reg");
    acc(1'b0, 8'h20, 32'h0, 32'h0, 1'b1, "R11 read of high reg");
    acc(1'b1, 8'h0C, 32'h1, 32'h0, 1'b1, "R11 write of id");
    acc(1'b0, 8'h02, 32'h0, 32'h0, 1'b1, "R11 misaligned");
    chk(irq_o == 1'b1 && cpy_valid == 1'b0, "R11 irq and copy kept", {62'h0, irq_o, cpy_valid}, 64'h2);
    rd(8'h0C, 32'hFFFF_FFFF, "R11 cursor kept");

    // rest of the pass
    rd(8'h00, 32'h8, "R3 to entry 1");
    rd(8'h0C, 32'h11, "R6 entry 1 id");
    rd(8'h00, 32'h8, "R3 to entry 2");
    rd(8'h1C, 32'd2, "R6 entry 2 count");
    rd(8'h00, 32'h8, "R3 to entry 3");
    rd(8'h10, 32'h1000_5000, "R6 entry 3 base");
    rd(8'h1C, 32'd0, "R6 entry 3 count");
    chk(irq_o == 1'b1, "R4 irq before finish", {63'h0, irq_o}, 64'h1);
    rd(8'h00, 32'h0, "R4 finished code");
    chk(irq_o == 1'b0, "R4 irq dropped", {63'h0, irq_o}, 64'h0);
    rd(8'h0C, 32'h0, "R6 id with no entry");
    rd(8'h00, 32'h0, "R5 reported entries skipped");
    acc(1'b1, 8'h04, 32'h4000_0000, 32'h0, 1'b0, "R9 name write no entry");
    @(negedge clk);
    chk(cpy_valid == 1'b0, "R9 no request without entry", {63'h0, cpy_valid}, 64'h0);
    chk(rsp_valid == 1'b0, "R12 single response", {63'h0, rsp_valid}, 64'h0);

    // new pass lists everything again
    acc(1'b1, 8'h00, 32'h0, 32'h0, 1'b0, "R2 second start");
    rd(8'h00, 32'h8, "R5 relisted after start");
    rd(8'h18, 32'd1, "R7 self irq again");

    repeat (3) @(negedge clk);
    chk(q_data.size() == 0, "R12 all responses seen", 64'(q_data.size()), 64'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule